// File: doc/BRIEF.md
# Actuated Two-Road Signal Controller

This block runs the lamps of a crossing where a north-south road meets an east-west road. Each road has a red, a yellow and a green lamp. Timing is counted in ticks, and a tick is a fixed number of system clocks set by a parameter. With no demand the roads take turns. One road is green for a fixed number of ticks, then yellow, and then the other road gets its turn. The road that is not moving stays red for the whole green and yellow time of the other road.

Each road has a pedestrian button and a vehicle sensor. A press or a detection on the red road is held until that road turns yellow or green. A held pedestrian request ends the running green at once. A held vehicle request ends the running green only when the green road has had no vehicle for a set idle window. An early end still goes through the full yellow. An optional pair of protected left-turn arrows runs during the north-south green. The north-bound arrow leads the green, and the south-bound arrow trails it.

Top module: `actuated_signal_ctrl`

## Requirements
- R1: While reset is held, and for RESET_RED_TICKS ticks after it is released, both roads show red. The north-south road turns green on the first clock after that.
- R2: With no requests, a green lasts GREEN_TICKS ticks and a yellow lasts YELLOW_TICKS ticks. The roads alternate north-south, then east-west. A road stays red for GREEN_TICKS+YELLOW_TICKS ticks.
- R3: Each lamp vector is one-hot: bit 2 is red, bit 1 is yellow, bit 0 is green. The two roads are never both off red at the same time. The east-west road turns green only directly after the north-south yellow.
- R4: Every green is followed by a yellow that lasts exactly YELLOW_TICKS ticks, including a green that ended early.
- R5: A button press on the red road is sampled at a clock edge. The green road then shows yellow from the next clock edge after that one.
- R6: A button press or a vehicle detection for a road that shows green or yellow is ignored. It does not shorten the next green of the other road.
- R7: A vehicle detection on the red road ends the running green within two clock edges if the green road has had no detection for IDLE_TICKS ticks.
- R8: Each detection on the green road restarts its idle window. A vehicle request that is waiting cuts the green between IDLE_TICKS-1 and IDLE_TICKS ticks (plus two clocks) after the last detection on the green road.
- R9: The north-bound arrow is green for the first ARROW_GREEN_TICKS ticks of the north-south green. It is then yellow for ARROW_YELLOW_TICKS ticks, and red at all other times.
- R10: The south-bound arrow is green for the last ARROW_GREEN_TICKS ticks of a full north-south green. After such a green, it is yellow for the first ARROW_YELLOW_TICKS ticks of the north-south yellow. It is red at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nsPedBtn | input | 1 | Pedestrian request for the north-south road |
| ewPedBtn | input | 1 | Pedestrian request for the east-west road |
| nsVehSense | input | 1 | Vehicle sensor, north-south road |
| ewVehSense | input | 1 | Vehicle sensor, east-west road |
| nsLamp | output | 3 | North-south lamps {red, yellow, green} |
| ewLamp | output | 3 | East-west lamps {red, yellow, green} |
| northArrow | output | 3 | North-bound left arrow {red, yellow, green}, all zero when disabled |
| southArrow | output | 3 | South-bound left arrow {red, yellow, green}, all zero when disabled |

## Verification
The hardest case to reach is the idle-window cut (R8). A vehicle request must wait on the red road while detections on the green road keep restarting the idle timer. The cut may only happen once those detections stop. The bench gets there with a directed sequence at the start of a north-south green: a detection on the green road, then a detection on the red road, then detections on the green road spaced closer than the window. It then measures the clocks from the last detection to the yellow and checks that they fall inside the window. Seeded random pulses on all four inputs follow, while a monitor checks the yellow lengths, the green lengths and that the two roads are never both off red.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  typedef enum logic [2:0] {
    PH_ALLRED   = 3'd0,
    PH_NSGREEN  = 3'd1,
    PH_NSYELLOW = 3'd2,
    PH_EWGREEN  = 3'd3,
    PH_EWYELLOW = 3'd4
  } phase_t;

  // control -> datapath strobes
  typedef struct packed {
    logic restart;  // phase changes this cycle: clear tick prescaler and phase timer
    logic nsOpen;   // north-south shows green or yellow
    logic ewOpen;   // east-west shows green or yellow
  } strobe_t;

  localparam logic [2:0] LAMP_R = 3'b100;
  localparam logic [2:0] LAMP_Y = 3'b010;
  localparam logic [2:0] LAMP_G = 3'b001;
endpackage

// File: rtl/tlc_datapath.sv
module tlc_datapath
  import tlc_pkg::*;
#(
  parameter int CLKS_PER_TICK = 125_000_000,
  parameter int TIME_W        = 6,
  parameter int IDLE_TICKS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [1:0]        pedBtn,    // [0] north-south, [1] east-west
  input  logic [1:0]        vehSense,
  output logic              tick,
  output logic [TIME_W-1:0] elapsed,
  output logic [1:0]        pedReq,
  output logic [1:0]        vehReq,
  output logic [1:0]        idleMet
);
  localparam int PRE_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_TICK - 1);
  localparam int IDLE_W = $clog2(IDLE_TICKS + 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(IDLE_TICKS);

  logic [PRE_W-1:0] preCnt;
  logic [1:0] roadOpen;

  assign tick = (preCnt == PRE_LAST);
  assign roadOpen = {strb.ewOpen, strb.nsOpen};

  // tick prescaler, realigned at each phase change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    preCnt <= '0;
    else if (strb.restart || tick) preCnt <= '0;
    else                          preCnt <= preCnt + 1'b1;
  end

  // ticks spent in the current phase, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         elapsed <= '0;
    else if (strb.restart)             elapsed <= '0;
    else if (tick && (elapsed != '1))  elapsed <= elapsed + 1'b1;
  end

  // R2
  elapsed_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !strb.restart) |=> $stable(elapsed));

  for (genvar r = 0; r < 2; r++) begin : gRoad
    logic [IDLE_W-1:0] idleCnt;
    logic pedL, vehL;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                               idleCnt <= '0;
      else if (vehSense[r])                    idleCnt <= '0;
      else if (tick && (idleCnt != IDLE_MAX))  idleCnt <= idleCnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pedL <= 1'b0;
        vehL <= 1'b0;
      end else if (roadOpen[r]) begin
        pedL <= 1'b0;
        vehL <= 1'b0;
      end else begin
        pedL <= pedL | pedBtn[r];
        vehL <= vehL | vehSense[r];
      end
    end

    assign idleMet[r] = (idleCnt == IDLE_MAX);
    assign pedReq[r]  = pedL;
    assign vehReq[r]  = vehL;

    // R6
    open_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
      roadOpen[r] |=> (!pedL && !vehL));
    // R8
    idle_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
      vehSense[r] |=> !idleMet[r]);
  end
endmodule

// File: rtl/tlc_control.sv
module tlc_control
  import tlc_pkg::*;
#(
  parameter int TIME_W             = 6,
  parameter int GREEN_TICKS        = 55,
  parameter int YELLOW_TICKS       = 5,
  parameter int RESET_RED_TICKS    = 1,
  parameter bit LEFT_ARROW         = 1'b1,
  parameter int ARROW_GREEN_TICKS  = 10,
  parameter int ARROW_YELLOW_TICKS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [TIME_W-1:0] elapsed,
  input  logic [1:0]        pedReq,
  input  logic [1:0]        vehReq,
  input  logic [1:0]        idleMet,
  output strobe_t           strb,
  output logic [2:0]        nsLamp,
  output logic [2:0]        ewLamp,
  output logic [2:0]        northArrow,
  output logic [2:0]        southArrow
);
  localparam logic [TIME_W-1:0] G_LAST  = TIME_W'(GREEN_TICKS - 1);
  localparam logic [TIME_W-1:0] Y_LAST  = TIME_W'(YELLOW_TICKS - 1);
  localparam logic [TIME_W-1:0] RR_LAST = TIME_W'(RESET_RED_TICKS - 1);

  phase_t phase, nextPhase;
  logic nsTimeout, ewTimeout, nsCut, ewCut, fullGreen;

  assign nsTimeout = tick && (elapsed == G_LAST);
  assign ewTimeout = nsTimeout;
  assign nsCut = pedReq[1] | (vehReq[1] & idleMet[0]);
  assign ewCut = pedReq[0] | (vehReq[0] & idleMet[1]);

  always_comb begin
    nextPhase = phase;
    case (phase)
      PH_ALLRED:   if (tick && (elapsed == RR_LAST)) nextPhase = PH_NSGREEN;
      PH_NSGREEN:  if (nsTimeout || nsCut)           nextPhase = PH_NSYELLOW;
      PH_NSYELLOW: if (tick && (elapsed == Y_LAST))  nextPhase = PH_EWGREEN;
      PH_EWGREEN:  if (ewTimeout || ewCut)           nextPhase = PH_EWYELLOW;
      PH_EWYELLOW: if (tick && (elapsed == Y_LAST))  nextPhase = PH_NSGREEN;
      default:                                       nextPhase = PH_ALLRED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_ALLRED;
      fullGreen <= 1'b0;
    end else begin
      phase <= nextPhase;
      if (phase == PH_NSGREEN && nextPhase != phase) fullGreen <= nsTimeout;
    end
  end

  assign strb.restart = (nextPhase != phase);
  assign strb.nsOpen  = (phase == PH_NSGREEN) || (phase == PH_NSYELLOW);
  assign strb.ewOpen  = (phase == PH_EWGREEN) || (phase == PH_EWYELLOW);

  always_comb begin
    nsLamp = LAMP_R;
    ewLamp = LAMP_R;
    case (phase)
      PH_NSGREEN:  nsLamp = LAMP_G;
      PH_NSYELLOW: nsLamp = LAMP_Y;
      PH_EWGREEN:  ewLamp = LAMP_G;
      PH_EWYELLOW: ewLamp = LAMP_Y;
      default: ;
    endcase
  end

  if (LEFT_ARROW) begin : gArrow
    localparam logic [TIME_W-1:0] AG_END = TIME_W'(ARROW_GREEN_TICKS);
    localparam logic [TIME_W-1:0] AY_END = TIME_W'(ARROW_GREEN_TICKS + ARROW_YELLOW_TICKS);
    localparam logic [TIME_W-1:0] SG_BEG = TIME_W'(GREEN_TICKS - ARROW_GREEN_TICKS);
    localparam logic [TIME_W-1:0] SY_END = TIME_W'(ARROW_YELLOW_TICKS);
    always_comb begin
      northArrow = LAMP_R;
      southArrow = LAMP_R;
      if (phase == PH_NSGREEN) begin
        if (elapsed < AG_END)      northArrow = LAMP_G;
        else if (elapsed < AY_END) northArrow = LAMP_Y;
        if (elapsed >= SG_BEG)     southArrow = LAMP_G;
      end else if (phase == PH_NSYELLOW && fullGreen && elapsed < SY_END) begin
        southArrow = LAMP_Y;
      end
    end
    // R9
    arrow_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot(northArrow) && $onehot(southArrow));
  end else begin : gNoArrow
    assign northArrow = '0;
    assign southArrow = '0;
  end

  // R4
  ns_green_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nsLamp == LAMP_G) |=> (nsLamp == LAMP_G || nsLamp == LAMP_Y));
  // R4
  ew_green_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ewLamp == LAMP_G) |=> (ewLamp == LAMP_G || ewLamp == LAMP_Y));
  // R3
  ew_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ewLamp[0]) |-> $past(nsLamp[1]));
  // R5
  ns_ped_cut_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_NSGREEN && pedReq[1]) |=> (phase == PH_NSYELLOW));
  // R4
  yellow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_NSYELLOW && !(tick && elapsed == Y_LAST)) |=> (phase == PH_NSYELLOW));
endmodule

// File: rtl/actuated_signal_ctrl.sv
module actuated_signal_ctrl
  import tlc_pkg::*;
#(
  parameter int CLKS_PER_TICK      = 125_000_000,
  parameter int GREEN_TICKS        = 55,
  parameter int YELLOW_TICKS       = 5,
  parameter int RESET_RED_TICKS    = 1,
  parameter int IDLE_TICKS         = 16,
  parameter bit LEFT_ARROW         = 1'b1,
  parameter int ARROW_GREEN_TICKS  = 10,
  parameter int ARROW_YELLOW_TICKS = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       nsPedBtn,
  input  logic       ewPedBtn,
  input  logic       nsVehSense,
  input  logic       ewVehSense,
  output logic [2:0] nsLamp,
  output logic [2:0] ewLamp,
  output logic [2:0] northArrow,
  output logic [2:0] southArrow
);
  localparam int MAX_T  = (GREEN_TICKS > RESET_RED_TICKS) ? GREEN_TICKS : RESET_RED_TICKS;
  localparam int TIME_W = $clog2(MAX_T + 1);

  strobe_t strb;
  logic tick;
  logic [TIME_W-1:0] elapsed;
  logic [1:0] pedReq, vehReq, idleMet;

  tlc_datapath #(
    .CLKS_PER_TICK(CLKS_PER_TICK), .TIME_W(TIME_W), .IDLE_TICKS(IDLE_TICKS)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .pedBtn({ewPedBtn, nsPedBtn}), .vehSense({ewVehSense, nsVehSense}),
    .tick(tick), .elapsed(elapsed), .pedReq(pedReq), .vehReq(vehReq), .idleMet(idleMet)
  );

  tlc_control #(
    .TIME_W(TIME_W), .GREEN_TICKS(GREEN_TICKS), .YELLOW_TICKS(YELLOW_TICKS),
    .RESET_RED_TICKS(RESET_RED_TICKS), .LEFT_ARROW(LEFT_ARROW),
    .ARROW_GREEN_TICKS(ARROW_GREEN_TICKS), .ARROW_YELLOW_TICKS(ARROW_YELLOW_TICKS)
  ) uCtl (
    .clk(clk), .rstN(rstN), .tick(tick), .elapsed(elapsed),
    .pedReq(pedReq), .vehReq(vehReq), .idleMet(idleMet), .strb(strb),
    .nsLamp(nsLamp), .ewLamp(ewLamp), .northArrow(northArrow), .southArrow(southArrow)
  );
endmodule

// File: tb/sim_actuated_signal_ctrl.sv
module sim_actuated_signal_ctrl;
  localparam int CPT = 4;
  localparam int GT  = 12;
  localparam int YT  = 3;
  localparam int RRT = 2;
  localparam int IT  = 4;
  localparam int AGT = 3;
  localparam int AYT = 2;
  localparam logic [2:0] R = 3'b100, Y = 3'b010, G = 3'b001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nsPed = 1'b0, ewPed = 1'b0, nsVeh = 1'b0, ewVeh = 1'b0;
  logic [2:0] nsLamp, ewLamp, northArrow, southArrow;

  int tests = 0, fails = 0;
  int nsRun = 0, ewRun = 0, nsLastGreen = 0, ewLastGreen = 0, nsLastRed = 0, badCycles = 0;
  logic [2:0] prevNs = R, prevEw = R;
  bit finished = 0;

  always #4 clk = ~clk;

  actuated_signal_ctrl #(
    .CLKS_PER_TICK(CPT), .GREEN_TICKS(GT), .YELLOW_TICKS(YT), .RESET_RED_TICKS(RRT),
    .IDLE_TICKS(IT), .LEFT_ARROW(1'b1), .ARROW_GREEN_TICKS(AGT), .ARROW_YELLOW_TICKS(AYT)
  ) u0 (
    .clk(clk), .rstN(rstN), .nsPedBtn(nsPed), .ewPedBtn(ewPed),
    .nsVehSense(nsVeh), .ewVehSense(ewVeh),
    .nsLamp(nsLamp), .ewLamp(ewLamp), .northArrow(northArrow), .southArrow(southArrow)
  );

  function automatic int greenCycles();  return GT * CPT;        endfunction
  function automatic int yellowCycles(); return YT * CPT;        endfunction
  function automatic int redCycles();    return (GT + YT) * CPT; endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // phase-length monitor
  always @(negedge clk) begin
    if (!rstN) begin
      prevNs = R; prevEw = R; nsRun = 0; ewRun = 0;
    end else begin
      if (nsLamp != R && ewLamp != R) badCycles++;
      if (!$onehot(nsLamp) || !$onehot(ewLamp)) badCycles++;
      if (nsLamp != prevNs) begin
        if (prevNs == Y) check(nsRun == yellowCycles(), "R4 ns yellow length", nsRun, yellowCycles());
        if (prevNs == G) nsLastGreen = nsRun;
        if (prevNs == R) nsLastRed = nsRun;
        nsRun = 1;
      end else nsRun++;
      if (ewLamp != prevEw) begin
        if (prevEw == Y) check(ewRun == yellowCycles(), "R4 ew yellow length", ewRun, yellowCycles());
        if (prevEw == G) ewLastGreen = ewRun;
        ewRun = 1;
      end else ewRun++;
      if ((nsLamp == G && nsRun > greenCycles()) || (ewLamp == G && ewRun > greenCycles())) badCycles++;
      prevNs = nsLamp;
      prevEw = ewLamp;
    end
  end

  task automatic waitNsGreenStart();
    do @(negedge clk); while (nsLamp == G);
    do @(negedge clk); while (nsLamp != G);
    #1;
  endtask

  task automatic waitEwGreenStart();
    do @(negedge clk); while (ewLamp == G);
    do @(negedge clk); while (ewLamp != G);
    #1;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: nsPed = 1'b1;
      1: ewPed = 1'b1;
      2: nsVeh = 1'b1;
      default: ewVeh = 1'b1;
    endcase
    @(negedge clk);
    nsPed = 1'b0; ewPed = 1'b0; nsVeh = 1'b0; ewVeh = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    check(0, "watchdog", 0, 1);
    finish();
  end

  initial begin
    int t;
    int d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(nsLamp == R && ewLamp == R, "R1 red in reset", {nsLamp, ewLamp}, {R, R});
    rstN = 1'b1;
    check(nsLamp == R && ewLamp == R && northArrow == R, "R1 red after release", {nsLamp, ewLamp}, {R, R});
    repeat (RRT * CPT - 1) @(negedge clk);
    check(nsLamp == R, "R1 still red at end of all-red", nsLamp, R);
    @(negedge clk); #1;
    check(nsLamp == G && ewLamp == R, "R1 ns green after all-red", nsLamp, G);

    // arrows through a full ns green (offset t from green start)
    t = 0;
    check(northArrow == G && southArrow == R, "R9 north arrow leads", northArrow, G);
    repeat (AGT * CPT - t) @(negedge clk); t = AGT * CPT;
    check(northArrow == Y, "R9 north arrow yellow", northArrow, Y);
    repeat ((AGT + AYT) * CPT - t) @(negedge clk); t = (AGT + AYT) * CPT;
    check(northArrow == R, "R9 north arrow red", northArrow, R);
    repeat ((GT - AGT) * CPT - 1 - t) @(negedge clk); t = (GT - AGT) * CPT - 1;
    check(southArrow == R, "R10 south arrow red before trail", southArrow, R);
    @(negedge clk); t++;
    check(southArrow == G, "R10 south arrow trails", southArrow, G);
    repeat (GT * CPT - t) @(negedge clk); t = GT * CPT;
    check(nsLamp == Y && southArrow == Y, "R10 south arrow yellow", southArrow, Y);
    repeat ((GT + AYT) * CPT - t) @(negedge clk);
    check(southArrow == R, "R10 south arrow red", southArrow, R);

    // R2 fixed cycle
    waitNsGreenStart();
    check(nsLastGreen == greenCycles(), "R2 ns green length", nsLastGreen, greenCycles());
    check(ewLastGreen == greenCycles(), "R2 ew green length", ewLastGreen, greenCycles());
    check(nsLastRed == redCycles(), "R2 ns red length", nsLastRed, redCycles());

    // R6 ns requests while ns green are ignored
    repeat (2) @(negedge clk);
    pulse(0);
    repeat (3) @(negedge clk);
    pulse(2);
    waitEwGreenStart();
    check(nsLastGreen == greenCycles(), "R6 ns green not shortened", nsLastGreen, greenCycles());
    waitNsGreenStart();
    check(ewLastGreen == greenCycles(), "R6 ew green not cut by ignored request", ewLastGreen, greenCycles());

    // R5 pedestrian cut of ns green
    repeat (5) @(negedge clk);
    @(negedge clk); ewPed = 1'b1;
    @(negedge clk); ewPed = 1'b0;
    check(nsLamp == G, "R5 ns green one edge after press", nsLamp, G);
    @(negedge clk);
    check(nsLamp == Y, "R5 ns yellow two edges after press", nsLamp, Y);
    // R5 mirror on ew green
    waitEwGreenStart();
    repeat (5) @(negedge clk);
    @(negedge clk); nsPed = 1'b1;
    @(negedge clk); nsPed = 1'b0;
    @(negedge clk);
    check(ewLamp == Y, "R5 ew yellow two edges after press", ewLamp, Y);

    // R7 vehicle cut with idle ns road
    waitNsGreenStart();
    repeat (3) @(negedge clk);
    @(negedge clk); ewVeh = 1'b1;
    @(negedge clk); ewVeh = 1'b0;
    @(negedge clk);
    check(nsLamp == Y, "R7 idle green cut by waiting vehicle", nsLamp, Y);

    // R8 idle window restarted by detections
    waitNsGreenStart();
    @(negedge clk); nsVeh = 1'b1;
    @(negedge clk); nsVeh = 1'b0; ewVeh = 1'b1;
    @(negedge clk); ewVeh = 1'b0;
    for (int k = 0; k < 4; k++) begin
      repeat (5) @(negedge clk);
      nsVeh = 1'b1;
      @(negedge clk); nsVeh = 1'b0;
      check(nsLamp == G, "R8 green held while ns traffic", nsLamp, G);
    end
    d = 0;
    while (nsLamp == G && d < 100) begin @(negedge clk); d++; end
    check(d >= (IT - 1) * CPT + 1 && d <= IT * CPT + 2, "R8 cut after idle window", d, IT * CPT);
    waitNsGreenStart();
    check(ewLastGreen == greenCycles(), "R6 vehicle on open road not latched", ewLastGreen, greenCycles());

    // seeded random traffic
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      nsPed = ($urandom % 60) == 0;
      ewPed = ($urandom % 60) == 0;
      nsVeh = ($urandom % 15) == 0;
      ewVeh = ($urandom % 15) == 0;
    end
    @(negedge clk);
    nsPed = 1'b0; ewPed = 1'b0; nsVeh = 1'b0; ewVeh = 1'b0;
    repeat (4) @(negedge clk);
    check(badCycles == 0, "R3 exclusion, one-hot lamps, green bound", badCycles, 0);
    finish();
  end
endmodule